// File: doc/BRIEF.md
# Dual Timer/Counter with Modulo, Single-Shot, Cascade and Capture

Two 8-bit timer/counters advance on a shared prescaler tick. Each counter runs while both its start flag and its run flag are set. When the count equals its data register on a tick, the count returns to zero. That event is a time-out. It toggles the timer's output level and can raise a one-cycle interrupt request. The interrupt can fire on every time-out, or only on every second one. In modulo mode the timer keeps running after a time-out. In single mode hardware clears the start flag at the first time-out, so the timer stops.

Software sets the timers up through a small write-only register port. Each timer has its own control byte and data byte. Timer 0's control byte can join the two counters into one 16-bit counter. It can also arm a capture path, which latches the timer 0 count on a rising edge of an external input. Each output pin shows the toggling level, XORed with a polarity bit. A restart loads that level from an initial-level bit.

Top module: `twin_timer`

## Requirements
- R1: After reset both counts, both output pins, both interrupt requests and the capture value are 0, and both timers are stopped.
- R2: A control write whose start bit (bit 0) is 1 while the timer is stopped clears the count and the every-second phase, loads the output level from bit 4 and starts the timer. A start=1 write to a running timer does not clear the count.
- R3: A control write with start bit 0 stops the timer. The count is held.
- R4: The run bit (bit 1) pauses counting when 0 and resumes from the held value when 1. A count advances only when start and run are both 1.
- R5: The count changes only on cycles where tick_i is 1. On a tick where the count equals the data register, the count becomes 0, which is a time-out. Otherwise it increments. The period is data+1 ticks.
- R6: Each time-out toggles the timer's output level. The pin drives the level XOR the invert bit (bit 5).
- R7: With bit 3 at 0, irq pulses for one cycle on every time-out. With bit 3 at 1, it pulses only on the 2nd, 4th and later even time-outs counted from the last restart.
- R8: With bit 2 at 1 (single mode), the start flag is cleared at the first time-out and counting stops. With bit 2 at 0 the timer keeps running.
- R9: Bit 7 of control 0 (cascade) makes timer 0 a 16-bit counter compared against {data1,data0} and controlled by control 0. count1_o shows the upper byte. Timer 1 does not advance and raises no interrupt.
- R10: With bit 6 of control 0 set, a rising edge on cap_i latches the timer 0 count into capture_o. cap_i passes a two-stage synchronizer first. With bit 6 clear, edges are ignored.
- R11: Write addresses: 0 is control 0, 1 is data 0, 2 is control 1, 3 is data 1. A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Prescaler tick, count enable |
| cap_i | input | 1 | Asynchronous capture input |
| count0_o | output | 8 | Timer 0 count |
| count1_o | output | 8 | Timer 1 count, or upper byte when cascaded |
| capture_o | output | 16 | Latched timer 0 count |
| tmr0_o | output | 1 | Timer 0 output pin |
| tmr1_o | output | 1 | Timer 1 output pin |
| irq0_o | output | 1 | Timer 0 interrupt request pulse |
| irq1_o | output | 1 | Timer 1 interrupt request pulse |

## Verification
The timers are run with a tick on every cycle, on every third cycle and with no tick at all. These runs separate counting on the tick from counting on the clock. Period-2 runs are repeated with the every-second select off and on, which pins down the phase of the interrupt after a restart. Stop, pause, single-shot and repeated start writes each hold or clear the count in a different way. A cascade run with a compare value above 255 shows whether the upper byte joins the compare, and whether timer 1 stays quiet. A capture taken while the count is paused, and then repeated with capture disabled, shows both the latched value and that disabled edges are ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] A_CTRL0 = 2'd0;
  localparam logic [1:0] A_DATA0 = 2'd1;
  localparam logic [1:0] A_CTRL1 = 2'd2;
  localparam logic [1:0] A_DATA1 = 2'd3;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic cascade;
    logic cap_en;
    logic invert;
    logic level;
    logic every2;
    logic single;
    logic run;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output ctrl_t        ctrl0_o,
  output ctrl_t        ctrl1_o,
  output logic [W-1:0] data0_o,
  output logic [W-1:0] data1_o,
  output logic         ctrl0_we_o,
  output logic         ctrl1_we_o
);
  assign ctrl0_we_o = wr_en_i && (wr_addr_i == A_CTRL0);
  assign ctrl1_we_o = wr_en_i && (wr_addr_i == A_CTRL1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_o <= '0;
      ctrl1_o <= '0;
      data0_o <= '0;
      data1_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL0: ctrl0_o <= ctrl_t'(wr_data_i[7:0]);
        A_DATA0: data0_o <= wr_data_i;
        A_CTRL1: ctrl1_o <= ctrl_t'(wr_data_i[7:0]);
        default: data1_o <= wr_data_i;
      endcase
    end
  end

  // R11
  ctrl0_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0_o != $past(ctrl0_o)) |-> $past(wr_en_i && wr_addr_i == A_CTRL0));
  // R11
  data1_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data1_o != $past(data1_o)) |-> $past(wr_en_i && wr_addr_i == A_DATA1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          freeze_i,
  input  logic          wide_i,
  input  logic          ctrl_we_i,
  input  logic          start_wr_i,
  input  logic          level_wr_i,
  input  ctrl_t         cfg_i,
  input  logic [CW-1:0] cmp_i,
  output logic [CW-1:0] cnt_o,
  output logic          out_o,
  output logic          irq_o
);
  localparam logic [W-1:0]  ONE_W = W'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt_q, cnt_inc;
  logic start_q, phase_q, lvl_q, irq_q;
  logic hit, adv, restart;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i.cascade, cfg_i.cap_en, cfg_i.level, cfg_i.start};

  assign adv     = start_q && cfg_i.run && tick_i && !freeze_i;
  assign restart = ctrl_we_i && start_wr_i && !start_q;

  generate
    if (CW > W) begin : g_wide
      always_comb begin
        if (wide_i) begin
          hit     = (cnt_q == cmp_i);
          cnt_inc = cnt_q + ONE_C;
        end else begin
          hit     = (cnt_q[W-1:0] == cmp_i[W-1:0]);
          cnt_inc = {{(CW-W){1'b0}}, cnt_q[W-1:0] + ONE_W};
        end
      end
    end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = wide_i;
      assign hit         = (cnt_q == cmp_i);
      assign cnt_inc     = cnt_q + ONE_C;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
      phase_q <= 1'b0;
      lvl_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= adv && hit && (!cfg_i.every2 || phase_q);
      if (restart) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
        lvl_q   <= level_wr_i;
        start_q <= 1'b1;
      end else begin
        if (adv) begin
          if (hit) begin
            cnt_q   <= '0;
            lvl_q   <= !lvl_q;
            phase_q <= !phase_q;
            if (cfg_i.single) start_q <= 1'b0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        // a software write to start wins over the single-mode clear
        if (ctrl_we_i) start_q <= start_wr_i;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = lvl_q ^ cfg_i.invert;
  assign irq_o = irq_q;

  // R5
  irq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == '0));
  // R4
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.run && !ctrl_we_i) |=> $stable(cnt_q));
  // R8
  single_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_q) && !$past(ctrl_we_i)) |-> $past(cfg_i.single));
  // R6
  lvl_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_q != $past(lvl_q)) && !$past(restart)) |-> (cnt_q == '0));
  // R7
  every2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_i.every2) && irq_q) |-> !phase_q);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          en_i,
  input  logic [CW-1:0] val_i,
  output logic [CW-1:0] cap_o
);
  logic s1_q, s2_q, s3_q;
  logic [CW-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      s1_q <= cap_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (en_i && s2_q && !s3_q) cap_q <= val_i;
    end
  end

  assign cap_o = cap_q;

  // R10
  cap_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q != $past(cap_q)) |-> $past(en_i));
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic           tick_i,
  input  logic           cap_i,
  output logic [W-1:0]   count0_o,
  output logic [W-1:0]   count1_o,
  output logic [2*W-1:0] capture_o,
  output logic           tmr0_o,
  output logic           tmr1_o,
  output logic           irq0_o,
  output logic           irq1_o
);
  localparam int unsigned CW = 2 * W;

  ctrl_t ctrl0, ctrl1;
  logic [W-1:0]  data0, data1, cnt1;
  logic [CW-1:0] cnt0;
  logic ctrl0_we, ctrl1_we, cascade;

  assign cascade = ctrl0.cascade;

  tmr_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .data0_o(data0), .data1_o(data1),
    .ctrl0_we_o(ctrl0_we), .ctrl1_we_o(ctrl1_we)
  );

  tmr_channel #(.W(W), .CW(CW)) u_ch0 (
    .clk_i, .rst_ni, .tick_i,
    .freeze_i(1'b0), .wide_i(cascade),
    .ctrl_we_i(ctrl0_we), .start_wr_i(wr_data_i[0]), .level_wr_i(wr_data_i[4]),
    .cfg_i(ctrl0), .cmp_i({data1, data0}),
    .cnt_o(cnt0), .out_o(tmr0_o), .irq_o(irq0_o)
  );

  tmr_channel #(.W(W), .CW(W)) u_ch1 (
    .clk_i, .rst_ni, .tick_i,
    .freeze_i(cascade), .wide_i(1'b0),
    .ctrl_we_i(ctrl1_we), .start_wr_i(wr_data_i[0]), .level_wr_i(wr_data_i[4]),
    .cfg_i(ctrl1), .cmp_i(data1),
    .cnt_o(cnt1), .out_o(tmr1_o), .irq_o(irq1_o)
  );

  tmr_capture #(.CW(CW)) u_cap (
    .clk_i, .rst_ni, .cap_i, .en_i(ctrl0.cap_en), .val_i(cnt0), .cap_o(capture_o)
  );

  assign count0_o = cnt0[W-1:0];
  assign count1_o = cascade ? cnt0[CW-1:W] : cnt1;

  // R9
  cascade_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cascade) |-> !irq1_o);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq0_o && !irq1_o));
endmodule

// File: tb/twin_timer_test.sv
`timescale 1ns/1ps
module twin_timer_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic tick_i = 1'b0;
  logic cap_i = 1'b0;
  logic [7:0] count0_o, count1_o;
  logic [15:0] capture_o;
  logic tmr0_o, tmr1_o, irq0_o, irq1_o;

  always #4 clk_i = ~clk_i;

  twin_timer uut (.*);

  int n_cmp = 0, n_bad = 0;
  int div = 1, tcnt = 0;
  int irq0_seen = 0, irq1_seen = 0;
  bit done = 1'b0, live = 1'b0;

  // behavioural reference model
  int m_cnt0, m_cnt1, m_data0, m_data1, m_cap;
  bit [7:0] m_ctrl0, m_ctrl1;
  bit m_start0, m_start1, m_ph0, m_ph1, m_lv0, m_lv1, m_irq0, m_irq1;
  bit m_s1, m_s2, m_s3;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt0 = 0; m_cnt1 = 0; m_data0 = 0; m_data1 = 0; m_cap = 0;
      m_ctrl0 = 0; m_ctrl1 = 0; m_start0 = 0; m_start1 = 0;
      m_ph0 = 0; m_ph1 = 0; m_lv0 = 0; m_lv1 = 0; m_irq0 = 0; m_irq1 = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit casc, en0, en1, hit0, hit1, n0, n1, os0, os1;
      casc = m_ctrl0[7];
      en0 = m_start0 && m_ctrl0[1] && tick_i;
      en1 = m_start1 && m_ctrl1[1] && tick_i && !casc;
      hit0 = casc ? (m_cnt0 == m_data1 * 256 + m_data0) : ((m_cnt0 % 256) == m_data0);
      hit1 = (m_cnt1 == m_data1);
      n0 = en0 && hit0 && (!m_ctrl0[3] || m_ph0);
      n1 = en1 && hit1 && (!m_ctrl1[3] || m_ph1);
      if (m_s2 && !m_s3 && m_ctrl0[6]) m_cap = m_cnt0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_i;
      os0 = m_start0; os1 = m_start1;
      if (en0) begin
        if (hit0) begin
          m_cnt0 = 0; m_lv0 = !m_lv0; m_ph0 = !m_ph0;
          if (m_ctrl0[2]) m_start0 = 0;
        end else m_cnt0 = casc ? (m_cnt0 + 1) % 65536 : (m_cnt0 % 256 + 1) % 256;
      end
      if (en1) begin
        if (hit1) begin
          m_cnt1 = 0; m_lv1 = !m_lv1; m_ph1 = !m_ph1;
          if (m_ctrl1[2]) m_start1 = 0;
        end else m_cnt1 = (m_cnt1 + 1) % 256;
      end
      m_irq0 = n0; m_irq1 = n1;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin
            if (wr_data_i[0] && !os0) begin
              m_cnt0 = 0; m_ph0 = 0; m_lv0 = wr_data_i[4]; m_start0 = 1;
            end else m_start0 = wr_data_i[0];
            m_ctrl0 = wr_data_i;
          end
          2'd1: m_data0 = wr_data_i;
          2'd2: begin
            if (wr_data_i[0] && !os1) begin
              m_cnt1 = 0; m_ph1 = 0; m_lv1 = wr_data_i[4]; m_start1 = 1;
            end else m_start1 = wr_data_i[0];
            m_ctrl1 = wr_data_i;
          end
          default: m_data1 = wr_data_i;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (live) begin
      bit casc;
      casc = m_ctrl0[7];
      check(count0_o == m_cnt0 % 256, "R5 count0", count0_o, m_cnt0 % 256);
      check(count1_o == (casc ? m_cnt0 / 256 : m_cnt1), "R9 count1", count1_o,
            casc ? m_cnt0 / 256 : m_cnt1);
      check(tmr0_o == (m_lv0 ^ m_ctrl0[5]), "R6 tmr0", tmr0_o, m_lv0 ^ m_ctrl0[5]);
      check(tmr1_o == (m_lv1 ^ m_ctrl1[5]), "R6 tmr1", tmr1_o, m_lv1 ^ m_ctrl1[5]);
      check(irq0_o == m_irq0, "R7 irq0", irq0_o, m_irq0);
      check(irq1_o == m_irq1, "R7 irq1", irq1_o, m_irq1);
      check(capture_o == m_cap, "R10 capture", capture_o, m_cap);
      if (irq0_o) irq0_seen++;
      if (irq1_o) irq1_seen++;
    end
  end

  task automatic drive(input bit we, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    tick_i = (div != 0) && (tcnt % div == 0);
    tcnt++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 8'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    live = 1'b1;
    idle(1);
    // r1_ reset state
    check(count0_o == 0 && count1_o == 0, "R1 counts", count0_o, 0);
    check(!irq0_o && !irq1_o && !tmr0_o && !tmr1_o, "R1 pins", irq0_o, 0);
    check(capture_o == 0, "R1 capture", capture_o, 0);

    // R5 R11 modulo run on both timers
    wr(2'd1, 8'd3); wr(2'd3, 8'd5);
    wr(2'd0, 8'h03); wr(2'd2, 8'h03);
    idle(20);
    // R2 start=1 write while running, no clear
    wr(2'd0, 8'h03); idle(10);
    // R4 pause, then resume
    wr(2'd0, 8'h01); idle(3); v = count0_o; idle(5);
    check(count0_o == v, "R4 paused count held", count0_o, v);
    wr(2'd0, 8'h03); idle(8);
    // R3 stop
    wr(2'd0, 8'h02); idle(3); v = count0_o; idle(5);
    check(count0_o == v, "R3 stopped count held", count0_o, v);
    // R2 restart with level 1
    wr(2'd0, 8'h13); idle(1);
    check(count0_o == 0, "R2 restart clears", count0_o, 0);
    check(tmr0_o == 1'b1, "R2 level loaded", tmr0_o, 1);
    // R6 invert on running timer
    wr(2'd0, 8'h33); idle(12);
    // R5 tick only every third cycle, then no tick
    div = 3; idle(30);
    div = 0; idle(2); v = count0_o; idle(6);
    check(count0_o == v, "R5 no tick no count", count0_o, v);
    div = 1;

    // R7 every-second interrupt, period 2
    wr(2'd0, 8'h00); wr(2'd1, 8'd1); idle(2);
    irq0_seen = 0;
    wr(2'd0, 8'h0B); idle(12);
    check(irq0_seen == 2, "R7 every second", irq0_seen, 2);
    wr(2'd0, 8'h00); idle(2);
    irq0_seen = 0;
    wr(2'd0, 8'h03); idle(12);
    check(irq0_seen == 5, "R7 every time-out", irq0_seen, 5);

    // R8 single mode
    wr(2'd0, 8'h00); wr(2'd1, 8'd3); idle(2);
    irq0_seen = 0;
    wr(2'd0, 8'h07); idle(20);
    check(irq0_seen == 1, "R8 one time-out", irq0_seen, 1);
    check(count0_o == 0, "R8 stopped at zero", count0_o, 0);
    wr(2'd0, 8'h07); idle(3);
    check(count0_o == 2, "R8 start cleared by hw", count0_o, 2);
    idle(10);

    // R9 cascade, compare 0x0104
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    wr(2'd1, 8'h04); wr(2'd3, 8'h01); idle(2);
    irq0_seen = 0; irq1_seen = 0;
    wr(2'd0, 8'h83); wr(2'd2, 8'h03); idle(599);
    check(irq0_seen == 2, "R9 16-bit period", irq0_seen, 2);
    check(irq1_seen == 0, "R9 timer1 quiet", irq1_seen, 0);
    wr(2'd0, 8'h00); idle(30);

    // R10 capture of a paused count
    wr(2'd1, 8'hFF); wr(2'd0, 8'h43); idle(10);
    wr(2'd0, 8'h41); idle(2); v = count0_o;
    cap_i = 1'b1; idle(5);
    check(capture_o == v, "R10 captured", capture_o, v);
    cap_i = 1'b0; idle(3);
    wr(2'd0, 8'h03); idle(5);
    cap_i = 1'b1; idle(5);
    check(capture_o == v, "R10 disabled edge ignored", capture_o, v);
    cap_i = 1'b0; idle(5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule